// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Byte Formatter

This block turns a parallel pixel stream into an 8-bit interleaved 4:2:2 byte stream. Line and frame timing travel inside the data as embedded reference codes, so no separate sync wires are needed. Each pixel arrives with one luma sample, both chroma samples and three timing flags: a horizontal active window that is high on the active span of every line, including lines in vertical blanking, a vertical blanking flag, and a field flag. The block emits two bytes per pixel, chroma first and then luma. Chroma alternates Cb and Cr, and every active line starts on Cb. Active samples are limited so that they never match a code preamble. Blanking intervals are filled with neutral black.

Every line carries a start code just before its first active byte and an end code just after its last active byte. Both codes are also sent on vertical blanking lines. Each code is the four bytes FF, 00, 00 and a status word. The status word holds the field, vertical blank and start/end flags, plus four protection bits. To place the start code ahead of the data, the block holds the stream back by two pixel slots.

A mode input selects the byte timing. In single-rate mode one byte leaves per clock, and a pixel is taken on every second clock. In double-rate mode the clock runs at the pixel rate and both bytes of a pixel leave in the same clock, on a rising-edge lane and a falling-edge lane, ready for an external DDR output cell. The `px_step` output tells the source on which clock edges a pixel is taken. Every horizontal blanking gap must be at least four pixels long, and every active window at least one pixel.

Top module: `vfmt_top`

## Requirements
- R1: While `rst` is high, both byte lanes read 0x80 and `px_step` is 1.
- R2: In double-rate mode `px_step` is 1 on every cycle. In single-rate mode it alternates 1, 0, 1, … and is 1 on the first cycle after reset.
- R3: Each pixel is sent as a chroma byte followed by a luma byte. Within an active line that is outside vertical blanking, the pixels at even positions (counted from 0 at the first active pixel) carry `px_cb` and the pixels at odd positions carry `px_cr`.
- R4: Active luma and chroma bytes are limited to the range 0x01 to 0xFE. Values below the range become 0x01 and values above it become 0xFE.
- R5: Outside the active window, and across the whole active window while `vblank` is 1, every pixel slot that does not carry a code is sent as chroma 0x80 and luma 0x10.
- R6: The four bytes FF, 00, 00, status (start flag H=0) come immediately before the first byte of each active window. F and V are taken from the first active pixel.
- R7: The four bytes FF, 00, 00, status (end flag H=1) come immediately after the last byte of each active window. F and V are taken from the first pixel after the window.
- R8: The status byte holds, from bit 7 down to bit 0: 1, F, V, H, V^H, F^H, F^V, F^V^H.
- R9: A pixel taken on a `px_step` edge leaves two pixel steps later. In double-rate mode it leaves after the second clock edge that follows, chroma on `byte_rise` and luma on `byte_fall`. In single-rate mode `byte_rise` shows its chroma after the fourth following edge and its luma after the fifth.
- R10: In single-rate mode `byte_fall` carries the same byte as `byte_rise` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock (single rate) or pixel clock (double rate) |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | 1 selects double-rate byte timing, 0 selects single rate |
| line_act | input | 1 | Horizontal active window, present on every line |
| vblank | input | 1 | Vertical blanking flag |
| field | input | 1 | Field flag |
| px_y | input | 8 | Luma sample |
| px_cb | input | 8 | Blue-difference chroma sample |
| px_cr | input | 8 | Red-difference chroma sample |
| px_step | output | 1 | High on clock edges where a pixel is taken |
| byte_rise | output | 8 | Rising-edge byte lane (the only byte in single-rate mode) |
| byte_fall | output | 8 | Falling-edge byte lane (a copy of the rising lane in single-rate mode) |

## Verification
On every cycle, the assertions check the pixel-step cadence in each mode, the lane mirroring in single-rate mode, and the structure of the double-rate stream. In that stream an FF byte must be followed by 00, the second lane never carries FF, and every status word that follows a preamble has a set top bit and consistent protection bits. Other behaviour can only be shown by the bench's line scenarios, which compare every output byte with an expected stream: that the codes sit exactly beside the active window, that Cb/Cr parity restarts on each line, the limit values, the blank fill during vertical blanking, the reset values and the exact latency.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

  // Kind of the pixel slot entering the delay stages.
  typedef enum logic [1:0] {
    SLOT_BLANK,
    SLOT_ACTIVE,
    SLOT_EAV_HEAD,
    SLOT_EAV_TAIL
  } slot_e;

  // Status word of a reference code: marker bit, flags, protection bits.
  function automatic logic [7:0] status_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vfmt_pixel.sv
module vfmt_pixel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              line_act,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] cb_in,
  input  logic [DATA_W-1:0] cr_in,
  output logic [DATA_W-1:0] c_out,
  output logic [DATA_W-1:0] y_out
);
  localparam int SH = DATA_W - 8;
  localparam logic [DATA_W-1:0] LIM_LO = DATA_W'(1) << SH;
  localparam logic [DATA_W-1:0] LIM_HI = {DATA_W{1'b1}} - LIM_LO;

  logic cr_turn;

  function automatic logic [DATA_W-1:0] limit(input logic [DATA_W-1:0] v);
    if (v < LIM_LO)      return LIM_LO;
    else if (v > LIM_HI) return LIM_HI;
    else                 return v;
  endfunction

  // Chroma phase restarts on Cb at every line start (window low -> 0).
  always_ff @(posedge clk) begin
    if (rst)       cr_turn <= 1'b0;
    else if (step) cr_turn <= line_act & ~cr_turn;
  end

  assign c_out = limit(cr_turn ? cr_in : cb_in);
  assign y_out = limit(y_in);

endmodule

// File: rtl/vfmt_timing.sv
module vfmt_timing
  import vfmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              line_act,
  input  logic              vblank,
  input  logic              field,
  output logic              sav_now,
  output slot_e             kind,
  output logic [DATA_W-1:0] sav_word,
  output logic [DATA_W-1:0] eav_word
);
  localparam int SH = DATA_W - 8;

  logic       act_q;
  logic       tail_due;
  logic [7:0] eav_q;
  logic       fall;

  assign fall    = act_q & ~line_act;
  assign sav_now = line_act & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      tail_due <= 1'b0;
      eav_q    <= 8'h00;
    end else if (step) begin
      act_q    <= line_act;
      tail_due <= fall;
      if (fall) eav_q <= status_word(field, vblank, 1'b1);
    end
  end

  always_comb begin
    if (line_act)      kind = vblank ? SLOT_BLANK : SLOT_ACTIVE;
    else if (fall)     kind = SLOT_EAV_HEAD;
    else if (tail_due) kind = SLOT_EAV_TAIL;
    else               kind = SLOT_BLANK;
  end

  assign sav_word = DATA_W'(status_word(field, vblank, 1'b0)) << SH;
  assign eav_word = DATA_W'(eav_q) << SH;

endmodule

// File: rtl/vfmt_serial.sv
module vfmt_serial #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ddr_mode,
  input  logic [DATA_W-1:0] pair_hi,
  input  logic [DATA_W-1:0] pair_lo,
  output logic              step,
  output logic [DATA_W-1:0] byte_rise,
  output logic [DATA_W-1:0] byte_fall
);
  localparam int SH = DATA_W - 8;
  localparam logic [DATA_W-1:0] FILL_C = DATA_W'(8'h80) << SH;
  localparam logic [DATA_W-1:0] FILL_Y = DATA_W'(8'h10) << SH;

  logic              phase;
  logic [DATA_W-1:0] hold;

  assign step = ddr_mode | ~phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      hold      <= FILL_Y;
      byte_rise <= FILL_C;
      byte_fall <= FILL_C;
    end else begin
      phase <= ddr_mode ? 1'b0 : ~phase;
      if (ddr_mode) begin
        byte_rise <= pair_hi;
        byte_fall <= pair_lo;
      end else if (step) begin
        byte_rise <= pair_hi;
        byte_fall <= pair_hi;
        hold      <= pair_lo;
      end else begin
        byte_rise <= hold;
        byte_fall <= hold;
      end
    end
  end

endmodule

// File: rtl/vfmt_top.sv
module vfmt_top
  import vfmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ddr_mode,
  input  logic              line_act,
  input  logic              vblank,
  input  logic              field,
  input  logic [DATA_W-1:0] px_y,
  input  logic [DATA_W-1:0] px_cb,
  input  logic [DATA_W-1:0] px_cr,
  output logic              px_step,
  output logic [DATA_W-1:0] byte_rise,
  output logic [DATA_W-1:0] byte_fall
);
  localparam int PAIR_W = 2 * DATA_W;
  localparam int SH     = DATA_W - 8;
  localparam logic [DATA_W-1:0] CODE_HI = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CODE_LO = {DATA_W{1'b0}};
  localparam logic [DATA_W-1:0] FILL_C  = DATA_W'(8'h80) << SH;
  localparam logic [DATA_W-1:0] FILL_Y  = DATA_W'(8'h10) << SH;
  localparam logic [PAIR_W-1:0] FILL_PAIR = {FILL_C, FILL_Y};

  logic              step;
  logic              sav_now;
  slot_e             kind;
  logic [DATA_W-1:0] sav_word, eav_word, c_px, y_px;
  logic [PAIR_W-1:0] incoming, emit, stage0, stage1, sav_head, sav_tail;

  vfmt_pixel #(.DATA_W(DATA_W)) u_pixel (
    .clk(clk), .rst(rst), .step(step), .line_act(line_act),
    .y_in(px_y), .cb_in(px_cb), .cr_in(px_cr),
    .c_out(c_px), .y_out(y_px)
  );

  vfmt_timing #(.DATA_W(DATA_W)) u_timing (
    .clk(clk), .rst(rst), .step(step), .line_act(line_act),
    .vblank(vblank), .field(field), .sav_now(sav_now), .kind(kind),
    .sav_word(sav_word), .eav_word(eav_word)
  );

  always_comb begin
    case (kind)
      SLOT_ACTIVE:   incoming = {c_px, y_px};
      SLOT_EAV_HEAD: incoming = {CODE_HI, CODE_LO};
      SLOT_EAV_TAIL: incoming = {CODE_LO, eav_word};
      default:       incoming = FILL_PAIR;
    endcase
  end

  // Start code overwrites the two blank slots already waiting ahead.
  assign sav_head = {CODE_HI, CODE_LO};
  assign sav_tail = {CODE_LO, sav_word};
  assign emit     = sav_now ? sav_head : stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage0 <= FILL_PAIR;
      stage1 <= FILL_PAIR;
    end else if (step) begin
      stage0 <= incoming;
      stage1 <= sav_now ? sav_tail : stage0;
    end
  end

  vfmt_serial #(.DATA_W(DATA_W)) u_serial (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode),
    .pair_hi(emit[PAIR_W-1:DATA_W]), .pair_lo(emit[DATA_W-1:0]),
    .step(step), .byte_rise(byte_rise), .byte_fall(byte_fall)
  );

  assign px_step = step;

endmodule

// File: rtl/vfmt_checker.sv
module vfmt_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ddr_mode,
  input logic              px_step,
  input logic [DATA_W-1:0] byte_rise,
  input logic [DATA_W-1:0] byte_fall
);
  logic [7:0] w;
  assign w = byte_fall[DATA_W-1 -: 8];

  p_sdr_alternate_r2: assert property (@(posedge clk) disable iff (rst)
    (!ddr_mode && !$past(ddr_mode) && !$past(rst)) |-> (px_step != $past(px_step)));

  p_ddr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ddr_mode && $past(ddr_mode)) |-> px_step);

  p_sdr_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(ddr_mode) |-> (byte_fall == byte_rise));

  // R6 and R7: a preamble byte on the rising lane pairs with zero.
  p_code_preamble_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(ddr_mode) && byte_rise == {DATA_W{1'b1}}) |-> (byte_fall == '0));

  p_fall_limit_r4: assert property (@(posedge clk) disable iff (rst)
    $past(ddr_mode) |-> (byte_fall != {DATA_W{1'b1}}));

  p_xy_protect_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(ddr_mode) && $past(ddr_mode, 2) && $past(byte_rise) == {DATA_W{1'b1}}
     && $past(byte_fall) == '0)
    |-> (byte_rise == '0 && w[7] && w[3] == (w[5] ^ w[4]) && w[2] == (w[6] ^ w[4])
         && w[1] == (w[6] ^ w[5]) && w[0] == (w[6] ^ w[5] ^ w[4])));

endmodule

bind vfmt_top vfmt_checker #(.DATA_W(DATA_W)) u_vfmt_checker (
  .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .px_step(px_step),
  .byte_rise(byte_rise), .byte_fall(byte_fall)
);

// File: tb/vfmt_top_test.sv
module vfmt_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES = 8;
  localparam int MAXP = 256;

  typedef struct packed {
    logic [7:0] lead;
    logic [7:0] alen;
    logic [7:0] tail;
    logic       vb;
    logic       fl;
    logic [7:0] y0;
    logic [7:0] ys;
    logic [7:0] cb;
    logic [7:0] cr;
  } line_t;

  // Stimulus lines: blank lead, active length, blank tail, flags, sample pattern.
  localparam line_t LINES [NLINES] = '{
    '{8'd4, 8'd6, 8'd4, 1'b0, 1'b0, 8'h20, 8'h11, 8'h40, 8'hC0},
    '{8'd5, 8'd7, 8'd2, 1'b0, 1'b1, 8'hF0, 8'h07, 8'h00, 8'hFF},
    '{8'd2, 8'd4, 8'd3, 1'b1, 1'b0, 8'h55, 8'h01, 8'h66, 8'h77},
    '{8'd3, 8'd1, 8'd2, 1'b1, 1'b1, 8'h99, 8'h00, 8'h11, 8'h22},
    '{8'd4, 8'd8, 8'd5, 1'b0, 1'b1, 8'h01, 8'h00, 8'hFE, 8'h01},
    '{8'd2, 8'd3, 8'd4, 1'b0, 1'b0, 8'hFF, 8'h00, 8'h80, 8'h10},
    '{8'd6, 8'd2, 8'd2, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h01, 8'hFE},
    '{8'd2, 8'd5, 8'd6, 1'b1, 1'b1, 8'h12, 8'h34, 8'h56, 8'h78}
  };

  logic       clk = 1'b0;
  logic       rst, ddr_mode, line_act, vblank, field;
  logic [7:0] px_y, px_cb, px_cr;
  logic       px_step;
  logic [7:0] byte_rise, byte_fall;

  logic       s_act [MAXP];
  logic       s_vb  [MAXP];
  logic       s_fl  [MAXP];
  logic [7:0] s_y   [MAXP];
  logic [7:0] s_cb  [MAXP];
  logic [7:0] s_cr  [MAXP];
  logic [7:0] e_hi  [MAXP];
  logic [7:0] e_lo  [MAXP];
  string      e_tag [MAXP];
  int         n_pix;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  vfmt_top #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .line_act(line_act),
    .vblank(vblank), .field(field), .px_y(px_y), .px_cb(px_cb), .px_cr(px_cr),
    .px_step(px_step), .byte_rise(byte_rise), .byte_fall(byte_fall)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] lim8(input logic [7:0] v);
    if (v < 8'h01) return 8'h01;
    if (v > 8'hFE) return 8'hFE;
    return v;
  endfunction

  // R8 layout of the status byte.
  function automatic logic [7:0] xy8(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic add_pix(input logic a, input logic vb, input logic fl,
                         input logic [7:0] y, input logic [7:0] cb, input logic [7:0] cr);
    s_act[n_pix] = a;  s_vb[n_pix] = vb; s_fl[n_pix] = fl;
    s_y[n_pix] = y;    s_cb[n_pix] = cb; s_cr[n_pix] = cr;
    e_hi[n_pix] = 8'h80; e_lo[n_pix] = 8'h10; e_tag[n_pix] = "R5 blank fill";
    n_pix++;
  endtask

  task automatic build();
    int a_start, a_end;
    logic [7:0] yv;
    n_pix = 0;
    for (int l = 0; l < NLINES; l++) begin
      for (int p = 0; p < int'(LINES[l].lead); p++)
        add_pix(1'b0, LINES[l].vb, LINES[l].fl, 8'h00, 8'h00, 8'h00);
      a_start = n_pix;
      for (int q = 0; q < int'(LINES[l].alen); q++) begin
        yv = 8'(int'(LINES[l].y0) + int'(LINES[l].ys) * q);
        add_pix(1'b1, LINES[l].vb, LINES[l].fl, yv, LINES[l].cb, LINES[l].cr);
        if (!LINES[l].vb) begin
          e_hi[n_pix-1]  = lim8((q % 2 == 0) ? LINES[l].cb : LINES[l].cr);
          e_lo[n_pix-1]  = lim8(yv);
          e_tag[n_pix-1] = "R3 R4 R9 active";
        end
      end
      a_end = n_pix;
      for (int p = 0; p < int'(LINES[l].tail); p++)
        add_pix(1'b0, LINES[l].vb, LINES[l].fl, 8'h00, 8'h00, 8'h00);
      e_hi[a_start-2] = 8'hFF; e_lo[a_start-2] = 8'h00; e_tag[a_start-2] = "R6 start preamble";
      e_hi[a_start-1] = 8'h00; e_lo[a_start-1] = xy8(LINES[l].fl, LINES[l].vb, 1'b0);
      e_tag[a_start-1] = "R6 R8 start status";
      e_hi[a_end] = 8'hFF; e_lo[a_end] = 8'h00; e_tag[a_end] = "R7 end preamble";
      e_hi[a_end+1] = 8'h00; e_lo[a_end+1] = xy8(LINES[l].fl, LINES[l].vb, 1'b1);
      e_tag[a_end+1] = "R7 R8 end status";
    end
    for (int p = 0; p < 4; p++) add_pix(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic drive_blank();
    line_act = 1'b0; vblank = 1'b0; field = 1'b0;
    px_y = 8'h00; px_cb = 8'h00; px_cr = 8'h00;
  endtask

  task automatic drive_pix(input int j);
    line_act = s_act[j]; vblank = s_vb[j]; field = s_fl[j];
    px_y = s_y[j]; px_cb = s_cb[j]; px_cr = s_cr[j];
  endtask

  task automatic run_seq(input logic ddr);
    int j, last;
    logic was;
    @(negedge clk);
    rst = 1'b1; ddr_mode = ddr; drive_blank();
    repeat (3) @(posedge clk);
    #1;
    chk(byte_rise == 8'h80, "R1 reset rise lane", byte_rise, 8'h80);
    chk(byte_fall == 8'h80, "R1 reset fall lane", byte_fall, 8'h80);
    chk(px_step == 1'b1, "R1 reset step", {7'd0, px_step}, 8'h01);
    @(negedge clk);
    rst = 1'b0;
    j = 0; last = -1;
    while (j < n_pix) begin
      was = px_step;
      if (was) drive_pix(j);
      @(posedge clk);
      #1;
      if (was) begin
        if (j >= 2) begin
          chk(byte_rise == e_hi[j-2], e_tag[j-2], byte_rise, e_hi[j-2]);
          if (ddr) chk(byte_fall == e_lo[j-2], e_tag[j-2], byte_fall, e_lo[j-2]);
        end
        last = j;
        j++;
      end else if (last >= 2) begin
        chk(byte_rise == e_lo[last-2], e_tag[last-2], byte_rise, e_lo[last-2]);
      end
      if (ddr) begin
        chk(px_step == 1'b1, "R2 double-rate step", {7'd0, px_step}, 8'h01);
      end else begin
        chk(px_step == !was, "R2 single-rate cadence", {7'd0, px_step}, {7'd0, !was});
        chk(byte_fall == byte_rise, "R10 lane mirror", byte_fall, byte_rise);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; ddr_mode = 1'b0; drive_blank();
    build();
    run_seq(1'b1);
    run_seq(1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule